// File: doc/BRIEF.md
# Debug Register File with Index Aliasing

This block holds the debug registers a processor core reaches through its move-to-debug-register and move-from-debug-register operations. There are four breakpoint address registers, one status register and one control register, each 64 bits wide. The execution pipeline presents one access per request: a 4-bit register index, a read/write direction, write data, the current privilege level, a flag saying whether the core runs in 64-bit mode, and the debug-extensions enable bit.

One cycle after each request the block pulses a done strobe. With the strobe it returns the read data and a 2-bit exception code. Before any register is touched, the block resolves the index. Two indices are aliases, or are illegal, depending on the debug-extensions bit. The block then applies the general-detect trap, which is kept in the control register, checks the privilege level, and checks the upper half of the operand. Breakpoint matching and hardware updates of the status bits are handled elsewhere.

Top module: `dbg_regfile`

## Requirements
- R1: After reset, rsp_done is 0, rsp_exc is 0 and rsp_rdata is 0. Every register reads back as 0, and the general-detect bit (control bit 13) is clear.
- R2: Indices 0 to 3 select the four breakpoint address registers. In 64-bit mode a write stores all 64 bits, and a later read of the same index returns them.
- R3: Index 6 selects the status register and index 7 selects the control register.
- R4: When dext_en is 0, index 4 accesses the status register and index 5 accesses the control register.
- R5: When dext_en is 1, index 4 and index 5 raise invalid opcode (rsp_exc = 2).
- R6: Indices 8 to 15 raise invalid opcode (rsp_exc = 2).
- R7: While control bit 13 is 1, every access raises the debug exception (rsp_exc = 1). This covers reads and writes to every index, including writes to the control register itself.
- R8: An access with cpl other than 0 raises general protection (rsp_exc = 3).
- R9: In 64-bit mode, a write to the status or control register (directly or through an alias) with any of bits 63:32 set raises general protection. A write to a breakpoint register with the upper bits set does not.
- R10: When mode64 is 0, read data has bits 63:32 at 0, and a write stores only bits 31:0, with the upper half cleared.
- R11: When more than one fault applies, invalid opcode wins over debug, and debug wins over general protection. Exception codes: 0 none, 1 debug, 2 invalid opcode, 3 general protection.
- R12: A faulting access changes no register and returns rsp_rdata = 0. Writes return rsp_rdata = 0.
- R13: rsp_done is 1 in exactly the cycle after each cycle with req_valid = 1, and 0 otherwise. While rsp_done is 0, rsp_exc and rsp_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_index | input | 4 | Register index |
| req_wdata | input | 64 | Write operand |
| req_cpl | input | 2 | Current privilege level |
| req_mode64 | input | 1 | Core runs in 64-bit mode |
| req_dext | input | 1 | Debug-extensions enable |
| rsp_done | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read result |
| rsp_exc | output | 2 | Exception code |

## Verification
Several fault conditions can apply to the same access. The hardest case is a general-detect trap combined with an aliased index and a non-zero privilege level: all three checks run in the same cycle, and the priority order must pick one winner. The bench first sets the general-detect bit. It then issues accesses that are also illegal by index, or made at non-zero privilege, or both, and compares each returned code with the order in R11. Random accesses with mixed privilege, mode and index exercise the other overlap: the upper-half check against the privilege check on status and control writes.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_DB   = 2'd1,
        EXC_UD   = 2'd2,
        EXC_GP   = 2'd3
    } exc_e;

    typedef enum logic [1:0] {
        SEL_BP   = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_BAD  = 2'd3
    } sel_e;

endpackage

// File: rtl/dbg_index_decode.sv
module dbg_index_decode
    import dbg_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int NUM_BP = 4,
    localparam int BP_W  = $clog2(NUM_BP)
) (
    input  logic [IDX_W-1:0] index,
    input  logic             dext,
    output sel_e             sel,
    output logic [BP_W-1:0]  bp_sel
);
    localparam int IDX_ALIAS_S = NUM_BP;
    localparam int IDX_ALIAS_C = NUM_BP + 1;
    localparam int IDX_STAT    = NUM_BP + 2;
    localparam int IDX_CTRL    = NUM_BP + 3;

    always_comb begin
        sel    = SEL_BAD;
        bp_sel = index[BP_W-1:0];
        if (int'(index) < NUM_BP) begin
            sel = SEL_BP;
        end else if (int'(index) == IDX_STAT) begin
            sel = SEL_STAT;
        end else if (int'(index) == IDX_CTRL) begin
            sel = SEL_CTRL;
        end else if (int'(index) == IDX_ALIAS_S) begin
            sel = dext ? SEL_BAD : SEL_STAT;
        end else if (int'(index) == IDX_ALIAS_C) begin
            sel = dext ? SEL_BAD : SEL_CTRL;
        end
    end

endmodule

// File: rtl/dbg_fault_prio.sv
module dbg_fault_prio
    import dbg_pkg::*;
(
    input  sel_e       sel,
    input  logic       gd_set,
    input  logic [1:0] cpl,
    input  logic       write,
    input  logic       mode64,
    input  logic       upper_nz,
    output exc_e       exc
);
    logic f_ud;
    logic f_db;
    logic f_gp;

    always_comb begin
        f_ud = (sel == SEL_BAD);
        f_db = gd_set;
        f_gp = (cpl != 2'd0)
             || (write && mode64 && upper_nz
                 && ((sel == SEL_STAT) || (sel == SEL_CTRL)));
        if (f_ud)      exc = EXC_UD;
        else if (f_db) exc = EXC_DB;
        else if (f_gp) exc = EXC_GP;
        else           exc = EXC_NONE;
    end

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4,
    parameter int NUM_BP = 4,
    parameter int GD_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_cpl,
    input  logic              req_mode64,
    input  logic              req_dext,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_exc
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BP_W   = $clog2(NUM_BP);

    typedef struct packed {
        logic [NUM_BP-1:0][DATA_W-1:0] bp;
        logic [DATA_W-1:0]             stat;
        logic [DATA_W-1:0]             ctrl;
        logic                          done;
        exc_e                          exc;
        logic [DATA_W-1:0]             rdata;
    } state_t;

    state_t st_d, st_q;

    sel_e              sel;
    logic [BP_W-1:0]   bp_sel;
    exc_e              exc;
    logic              upper_nz;
    logic [DATA_W-1:0] wval;
    logic [DATA_W-1:0] rval;

    dbg_index_decode #(.IDX_W(IDX_W), .NUM_BP(NUM_BP)) u_dec (
        .index  (req_index),
        .dext   (req_dext),
        .sel    (sel),
        .bp_sel (bp_sel)
    );

    assign upper_nz = |req_wdata[DATA_W-1:HALF_W];

    dbg_fault_prio u_prio (
        .sel      (sel),
        .gd_set   (st_q.ctrl[GD_BIT]),
        .cpl      (req_cpl),
        .write    (req_write),
        .mode64   (req_mode64),
        .upper_nz (upper_nz),
        .exc      (exc)
    );

    always_comb begin
        wval = req_mode64 ? req_wdata
                          : {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};
        case (sel)
            SEL_BP:   rval = st_q.bp[bp_sel];
            SEL_STAT: rval = st_q.stat;
            SEL_CTRL: rval = st_q.ctrl;
            default:  rval = '0;
        endcase
        if (!req_mode64) rval[DATA_W-1:HALF_W] = '0;
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = req_valid;
        st_d.exc   = EXC_NONE;
        st_d.rdata = '0;
        if (req_valid) begin
            st_d.exc = exc;
            if (exc == EXC_NONE) begin
                if (req_write) begin
                    case (sel)
                        SEL_BP:   st_d.bp[bp_sel] = wval;
                        SEL_STAT: st_d.stat       = wval;
                        SEL_CTRL: st_d.ctrl       = wval;
                        default:  ;
                    endcase
                end else begin
                    st_d.rdata = rval;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_done  = st_q.done;
    assign rsp_rdata = st_q.rdata;
    assign rsp_exc   = st_q.exc;

endmodule

// File: rtl/dbg_regfile_chk.sv
module dbg_regfile_chk #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_index,
    input logic              req_mode64,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [1:0]        rsp_exc
);
    localparam int HALF_W = DATA_W / 2;

    a_r13_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    a_r13_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_exc == 2'd0 && rsp_rdata == '0));

    a_r12_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_exc != 2'd0) |-> rsp_rdata == '0);

    a_r6_high_index_ud: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_index[IDX_W-1]) |=> rsp_exc == 2'd2);

    a_r10_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode64) |=> rsp_rdata[DATA_W-1:HALF_W] == '0);

endmodule

bind dbg_regfile dbg_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_index  (req_index),
    .req_mode64 (req_mode64),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .rsp_exc    (rsp_exc)
);

// File: tb/sim_dbg_regfile.sv
`timescale 1ns/1ps
module sim_dbg_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_index = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_cpl = '0;
    logic        req_mode64 = 1'b0;
    logic        req_dext = 1'b0;
    logic        rsp_done;
    logic [63:0] rsp_rdata;
    logic [1:0]  rsp_exc;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [63:0] m_bp [4];
    logic [63:0] m_stat;
    logic [63:0] m_ctrl;

    always #4 clk = ~clk;

    dbg_regfile u0 (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_bp[i] = '0;
        m_stat = '0;
        m_ctrl = '0;
    endtask

    // effective target: 0..3 bp, 6 stat, 7 ctrl, 15 illegal
    function automatic int eff_index(logic [3:0] idx, logic dext);
        if (idx < 4) return int'(idx);
        if (idx == 6 || idx == 7) return int'(idx);
        if (idx == 4 || idx == 5) return dext ? 15 : int'(idx) + 2;
        return 15;
    endfunction

    function automatic logic [1:0] exp_exc(logic wr, logic [3:0] idx, logic [63:0] d,
                                           logic [1:0] cpl, logic m64, logic dext);
        int e = eff_index(idx, dext);
        if (e == 15) return 2'd2;
        if (m_ctrl[13]) return 2'd1;
        if (cpl != 0) return 2'd3;
        if (wr && m64 && (e == 6 || e == 7) && d[63:32] != 0) return 2'd3;
        return 2'd0;
    endfunction

    task automatic access(string req, logic wr, logic [3:0] idx, logic [63:0] d,
                          logic [1:0] cpl, logic m64, logic dext);
        logic [1:0]  ee;
        logic [63:0] er;
        logic [63:0] wv;
        int e;
        ee = exp_exc(wr, idx, d, cpl, m64, dext);
        e  = eff_index(idx, dext);
        er = '0;
        if (ee == 2'd0 && !wr) begin
            if (e < 4) er = m_bp[e];
            else if (e == 6) er = m_stat;
            else er = m_ctrl;
            if (!m64) er[63:32] = '0;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = d;
        req_cpl = cpl; req_mode64 = m64; req_dext = dext;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " done"}, {63'd0, rsp_done}, 64'd1);
        check({req, " exc"}, {62'd0, rsp_exc}, {62'd0, ee});
        check({req, " rdata"}, rsp_rdata, er);
        if (ee == 2'd0 && wr) begin
            wv = m64 ? d : {32'd0, d[31:0]};
            if (e < 4) m_bp[e] = wv;
            else if (e == 6) m_stat = wv;
            else m_ctrl = wv;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 done", {63'd0, rsp_done}, 64'd0);
        check("R1 exc", {62'd0, rsp_exc}, 64'd0);
        check("R1 rdata", rsp_rdata, 64'd0);
        access("R1 ctrl reads zero", 0, 4'd7, 0, 0, 1, 0);

        // R2 breakpoint registers full width
        for (int i = 0; i < 4; i++)
            access("R2 bp write", 1, 4'(i), 64'hA5A5_0000_1111_0000 + 64'(i), 0, 1, 0);
        for (int i = 0; i < 4; i++)
            access("R2 bp read", 0, 4'(i), 0, 0, 1, 0);
        // R3 status and control
        access("R3 stat write", 1, 4'd6, 64'h0000_0000_0000_4001, 0, 1, 0);
        access("R3 ctrl write", 1, 4'd7, 64'h0000_0000_0000_0400, 0, 1, 0);
        access("R3 stat read", 0, 4'd6, 0, 0, 1, 0);
        // R4 aliases
        access("R4 alias ctrl read", 0, 4'd5, 0, 0, 1, 0);
        access("R4 alias stat write", 1, 4'd4, 64'h0000_0000_0000_0F0F, 0, 1, 0);
        access("R4 stat via 6", 0, 4'd6, 0, 0, 1, 0);
        // R5 aliases illegal with dext
        access("R5 idx4 dext", 0, 4'd4, 0, 0, 1, 1);
        access("R5 idx5 dext write", 1, 4'd5, 64'h1, 0, 1, 1);
        access("R5 ctrl unchanged", 0, 4'd7, 0, 0, 1, 0);
        // R6 high indices
        access("R6 idx8", 0, 4'd8, 0, 0, 1, 0);
        access("R6 idx15", 1, 4'd15, 64'h3, 0, 0, 0);
        // R8 privilege
        access("R8 cpl3 read", 0, 4'd0, 0, 2'd3, 1, 0);
        access("R8 cpl1 write", 1, 4'd1, 64'h99, 2'd1, 1, 0);
        access("R12 bp1 unchanged", 0, 4'd1, 0, 0, 1, 0);
        // R9 upper-bit checks
        access("R9 stat upper", 1, 4'd6, 64'h0000_0001_0000_0000, 0, 1, 0);
        access("R9 alias ctrl upper", 1, 4'd5, 64'h8000_0000_0000_0000, 0, 1, 0);
        access("R9 bp upper ok", 1, 4'd2, 64'hFFFF_FFFF_0000_0002, 0, 1, 0);
        access("R9 stat upper ignored 32b", 1, 4'd6, 64'hFFFF_FFFF_0000_0007, 0, 0, 0);
        access("R9 stat read", 0, 4'd6, 0, 0, 1, 0);
        // R10 32-bit mode
        access("R10 bp2 read 32", 0, 4'd2, 0, 0, 0, 0);
        access("R10 bp3 write 32", 1, 4'd3, 64'hDEAD_BEEF_1234_5678, 0, 0, 0);
        access("R10 bp3 read 64", 0, 4'd3, 0, 0, 1, 0);

        // random mix, general-detect kept clear
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] d;
            logic [1:0]  c;
            d = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 0) d[63:32] = '0;
            d[13] = 1'b0;
            c = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            access("R2 R11 random", 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                   d, c, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        // R7 general-detect trap
        access("R7 set gd", 1, 4'd7, 64'h0000_0000_0000_2000, 0, 1, 0);
        access("R7 read bp", 0, 4'd0, 0, 0, 1, 0);
        access("R7 write ctrl clear", 1, 4'd7, 64'h0, 0, 1, 0);
        access("R7 read ctrl", 0, 4'd7, 0, 0, 0, 0);
        // R11 priority
        access("R11 ud over db", 0, 4'd4, 0, 0, 1, 1);
        access("R11 ud over db gp", 0, 4'd12, 0, 2'd3, 1, 0);
        access("R11 db over gp", 0, 4'd5, 0, 2'd2, 1, 0);
        access("R11 db over upper gp", 1, 4'd6, 64'hFFFF_0000_0000_0000, 0, 1, 0);

        // R1 reset clears general-detect
        do_reset();
        access("R1 gd cleared", 0, 4'd7, 0, 0, 1, 0);
        access("R1 bp cleared", 0, 4'd3, 0, 0, 1, 0);
        @(negedge clk);
        check("R13 done drops", {63'd0, rsp_done}, 64'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule